// File: doc/BRIEF.md
# Shared-Counter Multi-Channel PWM Timer

This peripheral produces several edge-aligned PWM waveforms from one free-running up-counter. A power-of-two prescaler sets the counter's tick rate, a modulo register sets the terminal count, and every compare channel shares that counter. All channels therefore run at the same period, and each channel sets its own duty through a compare value. Software programs the block through a simple 32-bit register bus with separate read and write strobes. A read returns its data one clock after the strobe.

The period and compare values are double-buffered. While the counter is stopped, a write takes effect at once. While the counter is enabled, a write lands in a shadow copy that is promoted when the counter wraps to zero. Readback always shows the active copy, so software can poll until the new value has landed. The mode and polarity bits of a channel act at once. Each channel also has a compare-match flag that is cleared by writing 1 to it.

Register byte offsets:

| Offset | Register |
|---|---|
| 0x04 | Channel-count register |
| 0x08 | Reserved; reads 0 |
| 0x10 | Timer control |
| 0x14 | Count |
| 0x18 | Modulo |
| 0x20 + 8·n | Control of channel n |
| 0x24 + 8·n | Compare value of channel n |

Top module: `pwm_shared_timer`

## Requirements
- R1: After reset every output is low, the counter is stopped at 0, and the timer control, modulo and channel registers all read 0.
- R2: Bits 7:0 of the register at offset 0x04 read the number of channels (NCH). Writes to this register have no effect.
- R3: Timer control bits 2:0 (PS) and 4:3 (CM) select the counting. With CM=1 the counter advances once every 2^PS clocks, counts 0..MOD and then wraps to 0, so one period is (MOD+1)·2^PS clocks. With CM=0 the count holds its value.
- R4: A channel whose control has bit 5 set and bits 3:2 equal to 2'b10 drives its output high while count < value. A value of 0 gives 0% duty and a value above MOD gives 100% duty.
- R5: A channel whose control has bit 5 set and bits 3:2 equal to 2'b01 drives the complement of the R4 waveform.
- R6: A channel with bit 5 clear, or with bits 3:2 equal to 2'b00 or 2'b11, drives its output low.
- R7: With CM=0, a write to the modulo register (0x18) or to a compare value register takes effect and reads back at once.
- R8: With CM nonzero, such a write is held in a shadow copy. Readback keeps the old value until the counter next wraps to 0, when the new value becomes active.
- R9: Channel control bit 7 is set when CM=1 and the count equals the channel's compare value. Writing 1 to bit 7 clears it, and writing 0 to bit 7 leaves it unchanged.
- R10: Any write to the count register (0x14) resets the count to 0.
- R11: A write to channel control bits 5:2 changes that channel's output within two clocks, without waiting for a period boundary.
- R12: Timer control bit 5 always reads 0. A read of timer control returns PS and CM as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after bus_rd |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
The bench builds the block with NCH=3 and CNT_W=8. With three channels, one test can show 0%, 100% and intermediate duty side by side. The 8-bit counter keeps every period short enough to measure duty exactly over whole periods. It also lets a compare value above MOD force 100% duty. A prescaler setting of 2 stretches the period fourfold, and a setting of 3 leaves enough clocks between wraps to catch the shadowed value before it is promoted.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  localparam int OFF_PARAM   = 'h04;
  localparam int OFF_GLOBAL  = 'h08;
  localparam int OFF_CTRL    = 'h10;
  localparam int OFF_COUNT   = 'h14;
  localparam int OFF_MODULO  = 'h18;
  localparam int OFF_CH_BASE = 'h20;
  localparam int CH_STRIDE   = 8;
  localparam int PS_W        = 3;

  localparam logic [1:0] SEL_NORMAL   = 2'b10;
  localparam logic [1:0] SEL_INVERTED = 2'b01;
  localparam logic [1:0] CM_STOP      = 2'd0;
  localparam logic [1:0] CM_RUN       = 2'd1;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] pre_cnt;
  logic [DIV_W-1:0] mask;

  assign mask = ~({DIV_W{1'b1}} << ps);
  assign tick = run && ((pre_cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run) pre_cnt <= '0;
    else             pre_cnt <= pre_cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clr,
  input  logic             load_now,
  input  logic             mod_wr,
  input  logic [CNT_W-1:0] mod_wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] mod_act,
  output logic             wrap
);
  logic [CNT_W-1:0] mod_buf;

  assign wrap = tick && (cnt >= mod_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      mod_act <= '0;
      mod_buf <= '0;
    end else begin
      if (clr)       cnt <= '0;
      else if (tick) cnt <= wrap ? '0 : cnt + 1'b1;

      if (mod_wr) begin
        mod_buf <= mod_wdata;
        if (load_now) mod_act <= mod_wdata;
      end else if (wrap) begin
        mod_act <= mod_buf;
      end
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load_now,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ctrl_wr,
  input  logic [7:0]       ctrl_wdata,
  input  logic             val_wr,
  input  logic [CNT_W-1:0] val_wdata,
  output logic [7:0]       ctrl_rd,
  output logic [CNT_W-1:0] val_act,
  output logic             en,
  output logic             pwm_o
);
  import pwm_tmr_pkg::*;

  logic             mode_b, mode_a, flag;
  logic [1:0]       sel;
  logic [CNT_W-1:0] val_buf;
  logic             below;

  assign en      = mode_b && (sel == SEL_NORMAL || sel == SEL_INVERTED);
  assign below   = cnt < val_act;
  assign ctrl_rd = {flag, 1'b0, mode_b, mode_a, sel, 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_b  <= 1'b0;
      mode_a  <= 1'b0;
      sel     <= '0;
      flag    <= 1'b0;
      val_buf <= '0;
      val_act <= '0;
      pwm_o   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        mode_b <= ctrl_wdata[5];
        mode_a <= ctrl_wdata[4];
        sel    <= ctrl_wdata[3:2];
      end

      if (run && cnt == val_act)        flag <= 1'b1;
      else if (ctrl_wr && ctrl_wdata[7]) flag <= 1'b0;

      if (val_wr) begin
        val_buf <= val_wdata;
        if (load_now) val_act <= val_wdata;
      end else if (wrap) begin
        val_act <= val_buf;
      end

      pwm_o <= en && ((sel == SEL_INVERTED) ? !below : below);
    end
  end
endmodule

// File: rtl/pwm_shared_timer.sv
module pwm_shared_timer #(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  import pwm_tmr_pkg::*;

  logic [PS_W-1:0]  ps_q;
  logic [1:0]       cmod_q;
  logic             run, load_now, tick, wrap, cnt_clr, mod_wr;
  logic [CNT_W-1:0] cnt, mod_act;
  logic [NCH-1:0]   ch_en;
  logic [7:0]       ch_ctrl [NCH];
  logic [CNT_W-1:0] ch_val  [NCH];
  logic [31:0]      rd_mux;

  assign run      = cmod_q == CM_RUN;
  assign load_now = cmod_q == CM_STOP;
  assign cnt_clr  = bus_wr && bus_addr == ADDR_W'(OFF_COUNT);
  assign mod_wr   = bus_wr && bus_addr == ADDR_W'(OFF_MODULO);

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q   <= '0;
      cmod_q <= '0;
    end else if (bus_wr && bus_addr == ADDR_W'(OFF_CTRL)) begin
      ps_q   <= bus_wdata[PS_W-1:0];
      cmod_q <= bus_wdata[4:3];
    end
  end

  pwm_prescaler #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst(rst), .run(run), .ps(ps_q), .tick(tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .clr(cnt_clr), .load_now(load_now),
    .mod_wr(mod_wr), .mod_wdata(bus_wdata[CNT_W-1:0]),
    .cnt(cnt), .mod_act(mod_act), .wrap(wrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int CTRL_OFF = OFF_CH_BASE + CH_STRIDE * i;
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .run(run), .load_now(load_now), .wrap(wrap),
      .cnt(cnt),
      .ctrl_wr(bus_wr && bus_addr == ADDR_W'(CTRL_OFF)),
      .ctrl_wdata(bus_wdata[7:0]),
      .val_wr(bus_wr && bus_addr == ADDR_W'(CTRL_OFF + 4)),
      .val_wdata(bus_wdata[CNT_W-1:0]),
      .ctrl_rd(ch_ctrl[i]), .val_act(ch_val[i]), .en(ch_en[i]),
      .pwm_o(pwm_out[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFF_PARAM))  rd_mux = 32'(NCH);
    if (bus_addr == ADDR_W'(OFF_CTRL))   rd_mux = {27'd0, cmod_q, ps_q};
    if (bus_addr == ADDR_W'(OFF_COUNT))  rd_mux = 32'(cnt);
    if (bus_addr == ADDR_W'(OFF_MODULO)) rd_mux = 32'(mod_act);
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ADDR_W'(OFF_CH_BASE + CH_STRIDE * i))     rd_mux = 32'(ch_ctrl[i]);
      if (bus_addr == ADDR_W'(OFF_CH_BASE + CH_STRIDE * i + 4)) rd_mux = 32'(ch_val[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [NCH-1:0]    pwm_out,
  input logic [1:0]        cmod_q,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  mod_act,
  input logic              tick,
  input logic              wrap,
  input logic              cnt_clr,
  input logic [NCH-1:0]    ch_en
);
  // R2
  param_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(4)) |=> bus_rdata[7:0] == 8'(NCH));

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt >= mod_act && !cnt_clr) |=> cnt == '0);

  // R3
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmod_q == 2'd0 && !cnt_clr) |=> $stable(cnt));

  // R6
  disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pwm_out & ~$past(ch_en)) == '0);

  // R8
  mod_shadow_chk: assert property (@(posedge clk) disable iff (rst)
    (cmod_q != 2'd0 && !wrap) |=> $stable(mod_act));
endmodule

bind pwm_shared_timer pwm_timer_chk #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pwm_out(pwm_out), .cmod_q(cmod_q), .cnt(cnt),
  .mod_act(mod_act), .tick(tick), .wrap(wrap), .cnt_clr(cnt_clr), .ch_en(ch_en)
);

// File: tb/tb_pwm_shared_timer.sv
module tb_pwm_shared_timer;
  localparam int NCH = 3;
  localparam int CNT_W = 8;
  localparam int ADDR_W = 8;

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] pwm_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_shared_timer #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut (.*);

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = 32'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = int'(bus_rdata);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic highs(input int ch, input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      h += int'(pwm_out[ch]);
    end
  endtask

  task automatic t_reset;
    int d;
    chk("R1 outputs", int'(pwm_out), 0);
    rd('h10, d); chk("R1 control", d, 0);
    rd('h14, d); chk("R1 count", d, 0);
    rd('h18, d); chk("R1 modulo", d, 0);
    rd('h20, d); chk("R1 ch0 control", d, 0);
    rd('h24, d); chk("R1 ch0 value", d, 0);
  endtask

  task automatic t_param;
    int d;
    rd('h04, d); chk("R2 channel count", d & 'hFF, NCH);
    wr('h04, 'hFF);
    rd('h04, d); chk("R2 write ignored", d & 'hFF, NCH);
  endtask

  task automatic t_stopped_write;
    int d;
    wr('h18, 9);
    rd('h18, d); chk("R7 modulo immediate", d, 9);
    wr('h24, 3);
    rd('h24, d); chk("R7 value immediate", d, 3);
    wr('h2C, 0);
    wr('h34, 10);
  endtask

  task automatic t_normal;
    int h;
    wr('h20, 'h28); wr('h28, 'h28); wr('h30, 'h28);
    wr('h10, 'h08);
    idle(20);
    highs(0, 40, h); chk("R4 value 3 of period 10", h, 12);
    highs(1, 40, h); chk("R4 value 0 gives 0%", h, 0);
    highs(2, 40, h); chk("R4 value above MOD gives 100%", h, 40);
  endtask

  task automatic t_inverted;
    int h;
    wr('h28, 'h24);
    idle(2);
    highs(1, 40, h); chk("R5/R11 inverted 0% becomes 100%", h, 40);
    wr('h20, 'h24);
    idle(2);
    highs(0, 40, h); chk("R5 inverted value 3", h, 28);
    wr('h20, 'h28);
  endtask

  task automatic t_reserved;
    int h;
    wr('h30, 'h2C);
    idle(2);
    highs(2, 40, h); chk("R6 reserved select 11", h, 0);
    wr('h30, 'h20);
    idle(2);
    highs(2, 40, h); chk("R6 reserved select 00", h, 0);
    wr('h30, 'h08);
    idle(2);
    highs(2, 40, h); chk("R6 mode bit clear", h, 0);
  endtask

  task automatic t_prescale;
    int h;
    wr('h10, 'h00);
    wr('h10, 'h0A);
    idle(50);
    highs(0, 80, h); chk("R3 prescale 4 duty", h, 24);
  endtask

  task automatic t_count_clear;
    int a, b;
    wr('h10, 'h00);
    wr('h18, 200);
    wr('h14, 0);
    wr('h10, 'h08);
    idle(20);
    wr('h10, 'h00);
    rd('h14, a);
    chk("R3 counter advanced", int'(a > 10 && a < 40), 1);
    idle(10);
    rd('h14, b); chk("R3 stopped count holds", b, a);
    wr('h14, 'h55);
    rd('h14, b); chk("R10 count cleared", b, 0);
  endtask

  task automatic t_shadow;
    int d;
    wr('h18, 9);
    wr('h24, 3);
    wr('h10, 'h0B);
    wr('h14, 0);
    wr('h24, 2);
    wr('h18, 5);
    rd('h24, d); chk("R8 value held in shadow", d, 3);
    rd('h18, d); chk("R8 modulo held in shadow", d, 9);
    idle(120);
    rd('h24, d); chk("R8 value promoted at wrap", d, 2);
    rd('h18, d); chk("R8 modulo promoted at wrap", d, 5);
  endtask

  task automatic t_flag;
    int d;
    idle(60);
    wr('h10, 'h00);
    rd('h20, d); chk("R9 flag set on match", (d >> 7) & 1, 1);
    wr('h20, 'h28);
    rd('h20, d); chk("R9 write 0 keeps flag", (d >> 7) & 1, 1);
    wr('h20, 'hA8);
    rd('h20, d); chk("R9 write 1 clears flag", (d >> 7) & 1, 0);
  endtask

  task automatic t_ctrl_bits;
    int d;
    wr('h10, 'h22);
    rd('h10, d); chk("R12 bit 5 reads 0", d, 'h02);
    wr('h10, 'h0F);
    rd('h10, d); chk("R12 control readback", d, 'h0F);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    t_reset;
    t_param;
    t_stopped_write;
    t_normal;
    t_inverted;
    t_reserved;
    t_prescale;
    t_count_clear;
    t_shadow;
    t_flag;
    t_ctrl_bits;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule